// File: doc/BRIEF.md
# Ring Contrast Saliency Classifier

This block gives a cheap salient / not-salient verdict for one pixel of interest. It is fed, in a single beat, the 3×3 neighbourhood around that pixel at each of several pyramid scales. The patch pixels are numbered in row-major order, and the pixel of interest is the middle one.

For each scale, the four pixels on one side of the centre are paired with the pixels diametrically across from them. The block forms the magnitude of each pair's difference and keeps the largest of the four. It then adds these per-scale peaks into a single score and compares the score with a threshold supplied alongside the patch.

The datapath is a three-stage pipeline that accepts a new patch on every clock. Building the pyramid and scanning the image are left to the surrounding logic.

Top module: `ring_contrast_saliency`

## Requirements
- R1: Pixel k (0..8, row-major) of scale l sits at bits [(9*l+k)*PIX_W +: PIX_W] of `patch_i`. Pixel k is paired with pixel 8-k for k = 0..3, and no other pairing contributes to the score.
- R2: Each pair contributes the magnitude of its difference, so swapping the two values gives the same score.
- R3: Within a scale, only the largest of the four pair magnitudes is kept.
- R4: `score_o` is the sum of the per-scale peaks over all LEVELS scales.
- R5: `decision_o` is 1 exactly when the score is greater than or equal to the threshold that arrived with the same patch.
- R6: A patch accepted with `in_valid_i` at clock edge n produces its result at edge n+3. A new patch can be accepted on every edge.
- R7: `score_valid_o` and `decision_valid_o` rise together and stay low when no patch was accepted. After reset both strobes are 0 and `score_o` is 0.
- R8: The centre pixel (k = 4) has no effect on the result.
- R9: At full-scale contrast the score reaches LEVELS*(2^PIX_W-1), here 1020, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Patch and threshold are presented this cycle |
| patch_i | input | LEVELS*9*PIX_W | Nine pixels per scale, scale 0 in the low bits |
| threshold_i | input | SCORE_W | Decision threshold for this patch |
| score_valid_o | output | 1 | `score_o` holds a fresh result |
| score_o | output | SCORE_W | Summed peak contrast |
| decision_valid_o | output | 1 | `decision_o` holds a fresh result |
| decision_o | output | 1 | 1 when the score reaches the threshold |

## Verification
Uniform rings with a single contrasting pair are placed in every pair slot and in both orientations. These separate a wrong pairing or a signed difference from correct behaviour, and streaming them back to back shows whether each threshold stays with its own patch. Patches with distinct per-scale contrasts and mixed pair magnitudes within a scale show whether the peak is selected and whether all scales are summed. Further patterns cover a strong contrast between adjacent, non-opposite pixels, a change of the centre pixel only, a score equal to the threshold, and full-scale values, which test pairing, centre independence, the comparison boundary and overflow.

// File: rtl/ring_contrast_saliency.sv
module ring_contrast_saliency #(
  parameter int PIX_W   = 8,
  parameter int LEVELS  = 4,
  parameter int SCORE_W = PIX_W + $clog2(LEVELS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid_i,
  input  logic [LEVELS*9*PIX_W-1:0]  patch_i,
  input  logic [SCORE_W-1:0]         threshold_i,
  output logic                       score_valid_o,
  output logic [SCORE_W-1:0]         score_o,
  output logic                       decision_valid_o,
  output logic                       decision_o
);

  localparam int PAIRS = 4;

  logic [PIX_W-1:0]   diff_q [LEVELS][PAIRS];
  logic [PIX_W-1:0]   peak_q [LEVELS];
  logic [PIX_W-1:0]   peak_d [LEVELS];
  logic [SCORE_W-1:0] thr_s1, thr_s2;
  logic               vld_s1, vld_s2;
  logic [SCORE_W-1:0] sum_d;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      wire [PIX_W-1:0] a = patch_i[(9*l+p)*PIX_W +: PIX_W];
      wire [PIX_W-1:0] b = patch_i[(9*l+8-p)*PIX_W +: PIX_W];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          diff_q[l][p] <= '0;
        else if (in_valid_i) diff_q[l][p] <= (a >= b) ? a - b : b - a;
    end
    wire [PIX_W-1:0] m01 = (diff_q[l][0] >= diff_q[l][1]) ? diff_q[l][0] : diff_q[l][1];
    wire [PIX_W-1:0] m23 = (diff_q[l][2] >= diff_q[l][3]) ? diff_q[l][2] : diff_q[l][3];
    assign peak_d[l] = (m01 >= m23) ? m01 : m23;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      peak_q[l] <= '0;
      else if (vld_s1) peak_q[l] <= peak_d[l];
  end

  always_comb begin
    sum_d = '0;
    for (int l = 0; l < LEVELS; l++) sum_d = sum_d + SCORE_W'(peak_q[l]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s1 <= 1'b0;
      vld_s2 <= 1'b0;
      thr_s1 <= '0;
      thr_s2 <= '0;
      score_valid_o    <= 1'b0;
      decision_valid_o <= 1'b0;
      score_o    <= '0;
      decision_o <= 1'b0;
    end else begin
      vld_s1 <= in_valid_i;
      vld_s2 <= vld_s1;
      if (in_valid_i) thr_s1 <= threshold_i;
      if (vld_s1)     thr_s2 <= thr_s1;
      score_valid_o    <= vld_s2;
      decision_valid_o <= vld_s2;
      if (vld_s2) begin
        score_o    <= sum_d;
        decision_o <= (sum_d >= thr_s2);
      end
    end
  end

endmodule

// File: rtl/ring_contrast_saliency_chk.sv
module ring_contrast_saliency_chk #(
  parameter int PIX_W   = 8,
  parameter int LEVELS  = 4,
  parameter int SCORE_W = PIX_W + $clog2(LEVELS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid_i,
  input logic [SCORE_W-1:0] threshold_i,
  input logic               score_valid_o,
  input logic [SCORE_W-1:0] score_o,
  input logic               decision_valid_o,
  input logic               decision_o
);
  localparam int MAX_SCORE = LEVELS * ((1 << PIX_W) - 1);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid_o == $past(in_valid_i, 3));

  a_r7_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid_o == decision_valid_o);

  a_r5_threshold_compare: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid_o |-> (decision_o == (score_o >= $past(threshold_i, 3))));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid_o |-> (score_o <= SCORE_W'(MAX_SCORE)));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !score_valid_o |-> $stable(score_o));
endmodule

bind ring_contrast_saliency ring_contrast_saliency_chk #(
  .PIX_W(PIX_W), .LEVELS(LEVELS), .SCORE_W(SCORE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .threshold_i(threshold_i),
  .score_valid_o(score_valid_o), .score_o(score_o),
  .decision_valid_o(decision_valid_o), .decision_o(decision_o)
);

// File: tb/ring_contrast_saliency_tb.sv
module ring_contrast_saliency_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int LEVELS = 4;
  localparam int SCORE_W = PIX_W + $clog2(LEVELS);
  localparam int N = 8;
  // one contrasting pair (slot J, values HI/LO) in a uniform ring F, centre C, same on every scale
  localparam int TJ  [N] = '{0,   1,   2,    3,   3,    0, 2,   1};
  localparam int THI [N] = '{200, 50,  0,    7,   255,  1, 100, 17};
  localparam int TLO [N] = '{50,  200, 255,  7,   0,    0, 130, 3};
  localparam int TF  [N] = '{10,  99,  0,    3,   128,  0, 5,   40};
  localparam int TC  [N] = '{0,   255, 0,    200, 9,    0, 5,   77};
  localparam int TTH [N] = '{600, 601, 1020, 1,   0,    4, 121, 0};
  localparam int TSC [N] = '{600, 600, 1020, 0,   1020, 4, 120, 56};
  localparam int TDC [N] = '{1,   0,   1,    0,   1,    1, 0,   1};

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [LEVELS*9*PIX_W-1:0] patch = '0;
  logic [SCORE_W-1:0] thr = '0;
  logic sv, dv, dec;
  logic [SCORE_W-1:0] score;
  int checks = 0, errors = 0;
  bit finished = 0;
  int saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_contrast_saliency #(.PIX_W(PIX_W), .LEVELS(LEVELS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .patch_i(patch),
    .threshold_i(thr), .score_valid_o(sv), .score_o(score),
    .decision_valid_o(dv), .decision_o(dec));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setpix(input int l, input int k, input int v);
    patch[(9*l+k)*PIX_W +: PIX_W] = PIX_W'(v);
  endtask

  task automatic fill_vec(input int i);
    for (int l = 0; l < LEVELS; l++) begin
      for (int k = 0; k < 9; k++) setpix(l, k, TF[i]);
      setpix(l, 4, TC[i]);
      setpix(l, TJ[i], THI[i]);
      setpix(l, 8 - TJ[i], TLO[i]);
    end
  endtask

  task automatic run_one(input int th, input int exp_s, input int exp_d, input string tag);
    @(negedge clk);
    thr = SCORE_W'(th);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk(sv, 0, {tag, " strobe early (R6)"});
    @(negedge clk);
    chk(sv & dv, 1, {tag, " strobes (R6 R7)"});
    chk(score, exp_s, {tag, " score"});
    chk(dec, exp_d, {tag, " decision (R5)"});
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(sv, 0, "R7 reset score strobe");
    chk(dv, 0, "R7 reset decision strobe");
    chk(score, 0, "R7 reset score");
    rst_n = 1;

    // R1 R2 R5 R6 R9: table streamed back to back, one patch per clock
    for (int i = 0; i < N + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk(sv, 1, $sformatf("R6 stream strobe vec %0d", i-3));
        chk(score, TSC[i-3], $sformatf("R1 R2 R9 stream score vec %0d", i-3));
        chk(dec, TDC[i-3], $sformatf("R5 stream decision vec %0d", i-3));
      end
      if (i < N) begin
        fill_vec(i);
        thr = SCORE_W'(TTH[i]);
        in_valid = 1;
      end else in_valid = 0;
    end

    // R7: idle cycles produce no strobe
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(sv | dv, 0, "R7 idle strobes");
    end

    // R4: distinct contrast per scale, 10+20+30+40
    patch = '0;
    for (int l = 0; l < LEVELS; l++) setpix(l, l, 10 * (l + 1));
    run_one(100, 100, 1, "R4 scale sum");

    // R3: mixed magnitudes on every scale, peak 60 each
    patch = '0;
    for (int l = 0; l < LEVELS; l++) begin
      setpix(l, 0, 5); setpix(l, 1, 60); setpix(l, 2, 30); setpix(l, 3, 2);
      setpix(l, 8, 0); setpix(l, 7, 0); setpix(l, 6, 0); setpix(l, 5, 0);
    end
    run_one(241, 240, 0, "R3 peak select");

    // R1: strong adjacent contrast but opposite pairs equal -> 0
    patch = '0;
    for (int l = 0; l < LEVELS; l++) begin
      setpix(l, 0, 255); setpix(l, 8, 255); setpix(l, 2, 255); setpix(l, 6, 255);
    end
    run_one(1, 0, 0, "R1 non-opposite ignored");

    // R8: only the centre pixel changes
    patch = '0;
    for (int l = 0; l < LEVELS; l++) begin setpix(l, 3, 90); setpix(l, 4, 0); end
    run_one(360, 360, 1, "R8 centre low");
    saved = int'(score);
    for (int l = 0; l < LEVELS; l++) setpix(l, 4, 255);
    run_one(360, saved, 1, "R8 centre high");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule